// File: doc/BRIEF.md
# Nonmultiplexed Host Memory Port

This block is a slave port through which an external 16-bit host processor reads and writes a local on-chip RAM. The host has its own address bus and its own data bus. It starts an access by asserting a chip select and one of two data strobes, and it picks the direction with a read/write line. The block samples these asynchronous host signals in the local clock domain. Each host access becomes exactly one single-word memory request, and a ready output holds the host until that request has completed.

The RAM is shared with the local processor. That processor has a simple request port. A small arbiter always serves the host first. When both sides want the RAM in the same cycle, the local request is stalled for one cycle and is then served. No address or control register cycle exists: every strobe is a complete memory transaction.

Top module: `host_mem_port`

## Requirements
- R1: The block starts a host access only when `host_cs_n` is 0 and exactly one of `host_ds1_n`/`host_ds2_n` is 0. With both strobes low, or with chip select high, no access starts, `host_rdy` stays 1 and memory is unchanged.
- R2: `host_rw` = 1 selects a read and 0 selects a write. The block drives `host_data` only during a read, and only from the point where ready has returned high until the strobe is released. At all other times the bus is high impedance.
- R3: A host write captures its address and data when the strobe is detected and performs one memory write. A later host read of that address returns the written word.
- R4: Take a strobe asserted between clock edges. `host_rdy` is 0 at the third and fourth rising edges after it and is 1 again after the fifth, when the read data is valid.
- R5: While `rst` is 1, `host_rdy` is 0 and host strobes are ignored. A write attempted during reset leaves memory unchanged.
- R6: When a host request and a local request reach the RAM in the same cycle, the host access is performed first. A local read of the same address returns the word the host has just written.
- R7: A local request that collides with a host request sees `loc_stall` = 1 for exactly one cycle. Without a host request, `loc_stall` stays 0.
- R8: The RAM holds 2^MEM_AW words, and both sides index it with the low MEM_AW address bits. Addresses that differ only above bit MEM_AW-1 reach the same word.
- R9: A local request with `loc_stall` = 0 is performed at the next rising edge. For a read, `loc_rdata` holds the word after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst | input | 1 | Synchronous active-high reset |
| host_cs_n | input | 1 | Host chip select, active low |
| host_ds1_n | input | 1 | Host data strobe 1, active low |
| host_ds2_n | input | 1 | Host data strobe 2, active low |
| host_rw | input | 1 | 1 = host read, 0 = host write |
| host_addr | input | 18 | Host word address |
| host_data | inout | 16 | Host data bus |
| host_rdy | output | 1 | 1 = host may finish its access |
| loc_req | input | 1 | Local processor RAM request |
| loc_we | input | 1 | Local request is a write |
| loc_addr | input | 18 | Local word address |
| loc_wdata | input | 16 | Local write data |
| loc_rdata | output | 16 | Local read data |
| loc_stall | output | 1 | Local request held this cycle |

## Verification
Host accesses are made through either data strobe. Writes followed by read-backs show that the data and address are captured and stored, and they separate the two strobe paths. Illegal strobe combinations and strobes asserted during reset must leave ready high (or low, in reset) and memory unchanged. This separates the strobe decode from a plain OR of the strobes. Local accesses are placed exactly in the host's request cycle, both to the same address and to a different one, so the stall length and the service order can be seen. A random host mix against a reference array, plus accesses at high aliased addresses, exercises the address path.

// File: rtl/hmp_pkg.sv
package hmp_pkg;
    localparam int HD_W = 16;
    localparam int HA_W = 18;

    typedef enum logic [1:0] {
        HS_IDLE,
        HS_REQ,
        HS_CAP,
        HS_HOLD
    } hstate_e;

    typedef struct packed {
        logic            we;
        logic [HA_W-1:0] addr;
        logic [HD_W-1:0] wdata;
    } mem_req_t;

    function automatic logic strobe_on(input logic cs_n, input logic ds1_n, input logic ds2_n);
        return !cs_n && (ds1_n ^ ds2_n);
    endfunction
endpackage

// File: rtl/hmp_strobe_sync.sv
module hmp_strobe_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic raw,
    output logic active,
    output logic start
);
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-1:0], raw};
    end

    assign active = sh[STAGES-1];
    assign start  = sh[STAGES-1] & ~sh[STAGES];
endmodule

// File: rtl/hmp_host_fsm.sv
module hmp_host_fsm
    import hmp_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            active,
    input  logic            rw,
    input  logic [HA_W-1:0] addr,
    input  logic [HD_W-1:0] wdata,
    input  logic [HD_W-1:0] ram_rdata,
    output logic            req_valid,
    output mem_req_t        req,
    output logic            rdy,
    output logic            hold_read,
    output logic [HD_W-1:0] rd_data
);
    hstate_e         state, state_nx;
    mem_req_t        req_q;
    logic            rdy_q;
    logic [HD_W-1:0] rd_q;

    always_comb begin
        state_nx = state;
        unique case (state)
            HS_IDLE: if (start) state_nx = HS_REQ;
            HS_REQ:  state_nx = HS_CAP;
            HS_CAP:  state_nx = HS_HOLD;
            HS_HOLD: if (!active) state_nx = HS_IDLE;
            default: state_nx = HS_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= HS_IDLE;
            rdy_q <= 1'b0;
            req_q <= '0;
            rd_q  <= '0;
        end else begin
            state <= state_nx;
            rdy_q <= (state_nx == HS_IDLE) || (state_nx == HS_HOLD);
            if (state == HS_IDLE && start) begin
                req_q.we    <= !rw;
                req_q.addr  <= addr;
                req_q.wdata <= wdata;
            end
            if (state == HS_CAP && !req_q.we) rd_q <= ram_rdata;
        end
    end

    assign req_valid = (state == HS_REQ);
    assign req       = req_q;
    assign rdy       = rdy_q;
    assign hold_read = (state == HS_HOLD) && !req_q.we;
    assign rd_data   = rd_q;
endmodule

// File: rtl/hmp_arbiter.sv
module hmp_arbiter
    import hmp_pkg::*;
#(
    parameter int MEM_AW = 10
) (
    input  logic              host_valid,
    input  mem_req_t          host_req,
    input  logic              loc_req,
    input  logic              loc_we,
    input  logic [HA_W-1:0]   loc_addr,
    input  logic [HD_W-1:0]   loc_wdata,
    output logic              ram_en,
    output logic              ram_we,
    output logic [MEM_AW-1:0] ram_addr,
    output logic [HD_W-1:0]   ram_wdata,
    output logic              loc_stall
);
    always_comb begin
        ram_en    = host_valid | loc_req;
        loc_stall = host_valid & loc_req;
        if (host_valid) begin
            ram_we    = host_req.we;
            ram_addr  = host_req.addr[MEM_AW-1:0];
            ram_wdata = host_req.wdata;
        end else begin
            ram_we    = loc_req & loc_we;
            ram_addr  = loc_addr[MEM_AW-1:0];
            ram_wdata = loc_wdata;
        end
    end
endmodule

// File: rtl/hmp_ram.sv
module hmp_ram #(
    parameter int AW = 10,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          en,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;
    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (en) begin
            if (we) mem[addr] <= wdata;
            rdata <= mem[addr];
        end
    end
endmodule

// File: rtl/host_mem_port.sv
module host_mem_port
    import hmp_pkg::*;
#(
    parameter int MEM_AW      = 10,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            host_cs_n,
    input  logic            host_ds1_n,
    input  logic            host_ds2_n,
    input  logic            host_rw,
    input  logic [HA_W-1:0] host_addr,
    inout  wire  [HD_W-1:0] host_data,
    output logic            host_rdy,
    input  logic            loc_req,
    input  logic            loc_we,
    input  logic [HA_W-1:0] loc_addr,
    input  logic [HD_W-1:0] loc_wdata,
    output logic [HD_W-1:0] loc_rdata,
    output logic            loc_stall
);
    logic              strobe_raw, strobe_act, strobe_start;
    logic              hreq_valid, hold_read, data_oe;
    mem_req_t          hreq;
    logic [HD_W-1:0]   host_rd, ram_rdata, ram_wdata;
    logic              ram_en, ram_we;
    logic [MEM_AW-1:0] ram_addr;

    assign strobe_raw = strobe_on(host_cs_n, host_ds1_n, host_ds2_n);

    hmp_strobe_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .raw(strobe_raw),
        .active(strobe_act), .start(strobe_start)
    );

    hmp_host_fsm u_fsm (
        .clk(clk), .rst(rst), .start(strobe_start), .active(strobe_act),
        .rw(host_rw), .addr(host_addr), .wdata(host_data),
        .ram_rdata(ram_rdata), .req_valid(hreq_valid), .req(hreq),
        .rdy(host_rdy), .hold_read(hold_read), .rd_data(host_rd)
    );

    hmp_arbiter #(.MEM_AW(MEM_AW)) u_arb (
        .host_valid(hreq_valid), .host_req(hreq),
        .loc_req(loc_req), .loc_we(loc_we), .loc_addr(loc_addr), .loc_wdata(loc_wdata),
        .ram_en(ram_en), .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata),
        .loc_stall(loc_stall)
    );

    hmp_ram #(.AW(MEM_AW), .DW(HD_W)) u_ram (
        .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
        .wdata(ram_wdata), .rdata(ram_rdata)
    );

    assign data_oe   = hold_read & strobe_raw;
    assign host_data = data_oe ? host_rd : 'z;
    assign loc_rdata = ram_rdata;
endmodule

// File: rtl/hmp_checker.sv
module hmp_checker (
    input logic clk,
    input logic rst,
    input logic host_rdy,
    input logic loc_stall,
    input logic strb_start,
    input logic data_oe
);
    a_r5_rdy_low_in_reset: assert property (@(posedge clk) $past(rst) |-> !host_rdy);

    a_r4_rdy_drops_after_start: assert property (@(posedge clk) disable iff (rst)
        strb_start |=> !host_rdy);

    a_r7_stall_single_cycle: assert property (@(posedge clk) disable iff (rst)
        loc_stall |=> !loc_stall);

    a_r6_host_busy_on_stall: assert property (@(posedge clk) disable iff (rst)
        loc_stall |-> !host_rdy);

    a_r2_drive_only_when_ready: assert property (@(posedge clk) disable iff (rst)
        data_oe |-> host_rdy);
endmodule

bind host_mem_port hmp_checker u_chk (
    .clk(clk), .rst(rst), .host_rdy(host_rdy), .loc_stall(loc_stall),
    .strb_start(strobe_start), .data_oe(data_oe)
);

// File: tb/tb_host_mem_port.sv
module tb_host_mem_port;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        host_cs_n = 1'b1, host_ds1_n = 1'b1, host_ds2_n = 1'b1, host_rw = 1'b1;
    logic [17:0] host_addr = '0;
    logic [15:0] tb_wd = '0;
    logic        tb_drv = 1'b0;
    tri   [15:0] hd;
    logic        host_rdy;
    logic        loc_req = 1'b0, loc_we = 1'b0;
    logic [17:0] loc_addr = '0;
    logic [15:0] loc_wdata = '0;
    logic [15:0] loc_rdata;
    logic        loc_stall;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mdl_mem [1024];

    assign hd = tb_drv ? tb_wd : 'z;

    always #4 clk = ~clk;

    host_mem_port dut (
        .clk(clk), .rst(rst), .host_cs_n(host_cs_n), .host_ds1_n(host_ds1_n),
        .host_ds2_n(host_ds2_n), .host_rw(host_rw), .host_addr(host_addr),
        .host_data(hd), .host_rdy(host_rdy), .loc_req(loc_req), .loc_we(loc_we),
        .loc_addr(loc_addr), .loc_wdata(loc_wdata), .loc_rdata(loc_rdata),
        .loc_stall(loc_stall)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic host_access(input bit rd, input logic [17:0] a, input logic [15:0] wd,
                               input bit use_ds2, output logic [15:0] rdv, output int lat);
        bit went_low;
        @(negedge clk);
        host_addr = a; host_rw = rd; tb_wd = wd; tb_drv = !rd;
        host_cs_n = 1'b0;
        if (use_ds2) host_ds2_n = 1'b0; else host_ds1_n = 1'b0;
        lat = 0; went_low = 0;
        do begin
            @(negedge clk);
            lat++;
            if (!host_rdy) went_low = 1;
            if (lat == 1) begin
                if (rd) chk("R2 bus undriven before ready", {16'h0, hd}, {16'h0, 16'hzzzz});
                else    chk("R2 no contention on write", {16'h0, hd}, {16'h0, wd});
            end
        end while (!(host_rdy && went_low) && lat < 20);
        rdv = hd;
        chk("R4 ready latency", lat, 5);
        @(negedge clk);
        host_cs_n = 1'b1; host_ds1_n = 1'b1; host_ds2_n = 1'b1; tb_drv = 1'b0;
        #1;
        chk("R2 bus released after strobe", {16'h0, hd}, {16'h0, 16'hzzzz});
        repeat (4) @(negedge clk);
    endtask

    task automatic hwrite(input logic [17:0] a, input logic [15:0] d, input bit ds2);
        logic [15:0] r; int l;
        host_access(1'b0, a, d, ds2, r, l);
        mdl_mem[a[9:0]] = d;
    endtask

    task automatic hread_chk(input string tag, input logic [17:0] a, input bit ds2);
        logic [15:0] r; int l;
        host_access(1'b1, a, 16'h0, ds2, r, l);
        chk(tag, {16'h0, r}, {16'h0, mdl_mem[a[9:0]]});
    endtask

    task automatic loc_access(input bit we, input logic [17:0] a, input logic [15:0] wd,
                              output logic [15:0] rdv, output int stalls);
        loc_req = 1'b1; loc_we = we; loc_addr = a; loc_wdata = wd;
        #1;
        stalls = 0;
        while (loc_stall && stalls < 5) begin
            stalls++;
            @(negedge clk);
            #1;
        end
        @(negedge clk);
        loc_req = 1'b0; loc_we = 1'b0;
        rdv = loc_rdata;
    endtask

    task automatic t_reset();
        repeat (3) @(negedge clk);
        chk("R5 ready low in reset", {31'h0, host_rdy}, 32'h1 ^ 32'h1);
        rst = 1'b0;
        @(negedge clk);
        chk("R5 ready high after reset", {31'h0, host_rdy}, 32'h1);
    endtask

    task automatic t_basic();
        hwrite(18'h00010, 16'hA55A, 1'b0);
        hwrite(18'h00011, 16'h1234, 1'b1);
        hwrite(18'h003FF, 16'hFFFF, 1'b0);
        hread_chk("R3 read back via ds1", 18'h00010, 1'b0);
        hread_chk("R3 read back via ds2", 18'h00011, 1'b1);
        hread_chk("R3 read back top word", 18'h003FF, 1'b1);
    endtask

    task automatic t_bad_strobes();
        hwrite(18'h00020, 16'h0F0F, 1'b0);
        @(negedge clk);
        host_addr = 18'h00020; host_rw = 1'b0; tb_wd = 16'hDEAD; tb_drv = 1'b1;
        host_cs_n = 1'b0; host_ds1_n = 1'b0; host_ds2_n = 1'b0;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 7) chk("R1 both strobes low ignored", {31'h0, host_rdy}, 32'h1);
        end
        host_cs_n = 1'b1; host_ds2_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            if (i == 7) chk("R1 chip select high ignored", {31'h0, host_rdy}, 32'h1);
        end
        host_ds1_n = 1'b1; tb_drv = 1'b0;
        repeat (3) @(negedge clk);
        hread_chk("R1 memory unchanged by bad strobes", 18'h00020, 1'b0);
    endtask

    task automatic t_reset_block();
        hwrite(18'h00030, 16'h5AA5, 1'b1);
        @(negedge clk);
        rst = 1'b1;
        host_addr = 18'h00030; host_rw = 1'b0; tb_wd = 16'hBEEF; tb_drv = 1'b1;
        host_cs_n = 1'b0; host_ds1_n = 1'b0;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            if (i == 5) chk("R5 ready low with strobe in reset", {31'h0, host_rdy}, 32'h0);
        end
        host_cs_n = 1'b1; host_ds1_n = 1'b1; tb_drv = 1'b0;
        @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        hread_chk("R5 write in reset ignored", 18'h00030, 1'b0);
    endtask

    task automatic t_alias();
        logic [15:0] r; int l;
        hwrite(18'h3C007, 16'h7007, 1'b0);
        host_access(1'b1, 18'h00007, 16'h0, 1'b1, r, l);
        chk("R8 upper address bits alias", {16'h0, r}, {16'h0, 16'h7007});
    endtask

    task automatic t_local();
        logic [15:0] r; int s;
        @(negedge clk);
        loc_access(1'b1, 18'h00040, 16'hC0DE, r, s);
        chk("R7 no stall without host", s, 0);
        loc_access(1'b0, 18'h00040, 16'h0, r, s);
        chk("R9 local read data", {16'h0, r}, {16'h0, 16'hC0DE});
        mdl_mem[10'h040] = 16'hC0DE;
        hread_chk("R9 host sees local write", 18'h00040, 1'b0);
    endtask

    task automatic t_conflict();
        logic [15:0] hr, lr; int hl, ls;
        fork
            host_access(1'b0, 18'h00050, 16'h9999, 1'b0, hr, hl);
            begin
                repeat (4) @(negedge clk);
                loc_access(1'b0, 18'h00050, 16'h0, lr, ls);
            end
        join
        mdl_mem[10'h050] = 16'h9999;
        chk("R7 stall one cycle on read conflict", ls, 1);
        chk("R6 local read after host write", {16'h0, lr}, {16'h0, 16'h9999});
        fork
            host_access(1'b1, 18'h00010, 16'h0, 1'b1, hr, hl);
            begin
                repeat (4) @(negedge clk);
                loc_access(1'b1, 18'h00060, 16'h6060, lr, ls);
            end
        join
        mdl_mem[10'h060] = 16'h6060;
        chk("R7 stall one cycle on write conflict", ls, 1);
        chk("R6 host read served during conflict", {16'h0, hr}, {16'h0, mdl_mem[10'h010]});
        hread_chk("R6 local write completed after stall", 18'h00060, 1'b0);
    endtask

    task automatic t_random();
        for (int i = 0; i < 8; i++) hwrite(18'h00100 + 18'(i), 16'(i * 16'h1111), i[0]);
        for (int i = 0; i < 30; i++) begin
            logic [17:0] a;
            a = 18'h00100 + 18'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 0) hwrite(a, 16'($urandom), 1'($urandom));
            else hread_chk("R3 random read vs model", a, 1'($urandom));
        end
    endtask

    initial begin
        #(8 * 150000);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_basic();
        t_bad_strobes();
        t_reset_block();
        t_alias();
        t_local();
        t_conflict();
        t_random();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule